// File: doc/BRIEF.md
# USB Host Resume Exit Controller

This block closes out a host-side resume after the bus has been in Suspend or in LPM sleep. When a resume begins, the controller moves the 2-bit PHY operating-mode output to non-driving mode. When the resume-end strobe arrives, it enters an exit phase. It returns the operating mode to normal when one of two conditions occurs: the line shows a single-ended zero, or a fixed cycle timeout expires. A configuration bit chooses between "timeout or SE0, whichever is first" and "SE0 only". The same sequence serves both Suspend and LPM exits, because the controller does not need to know which sleep state it is leaving.

A low-frequency suspend option adds a validation step while the resume is in progress. With the option on, the resume-valid flag rises only after the K line state has been seen for a programmable number of consecutive cycles. With the option off, the flag rises in the first resume cycle. When the exit completes, a one-cycle done pulse marks the return to normal mode, and the controller goes back to idle.

Top module: `rsm_exit_ctrl`

## Requirements
- R1: After synchronous reset, opmode is 2'b00, rsm_valid is 0 and exit_done is 0.
- R2: rsm_start sampled high in idle sets opmode to 2'b10 (non-driving) from the next cycle. opmode stays at 2'b10 through the resume phase and the exit phase.
- R3: With tmr_ignore = 0, rsm_end accepted at clock edge E0 starts the exit phase. opmode returns to 2'b00 at the first edge E0+k (k >= 1) where line_st was 2'b00 (SE0), or at edge E0+TIMEOUT, whichever is earlier (TIMEOUT = 200).
- R4: With tmr_ignore = 1, the timeout has no effect. The exit ends only at the first edge in the exit phase that samples line_st = 2'b00.
- R5: exit_done is high for exactly one cycle, in the same cycle that opmode first shows 2'b00. rsm_valid is 0 from that cycle on, and the controller is idle.
- R6: The timeout counter restarts from zero at every exit-phase entry, so an earlier sequence never shortens a later timeout.
- R7: With lf_susp_en = 1, rsm_valid rises after the resume-phase edge at which line_st = 2'b10 (K) has been sampled at val_count consecutive resume-phase edges (a val_count of 0 acts as 1). The flag then holds until the exit completes.
- R8: With lf_susp_en = 1, a resume-phase edge that samples any line state other than K resets the consecutive count to zero, and rsm_valid does not rise on the interrupted run.
- R9: With lf_susp_en = 0, rsm_valid rises after the first resume-phase edge, whatever the line state.
- R10: rsm_end outside the resume phase and rsm_start outside idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous active-high reset |
| line_st | input | 2 | Line state; 2'b00 = SE0, 2'b10 = K |
| rsm_start | input | 1 | Resume start strobe |
| rsm_end | input | 1 | Resume end strobe, begins exit phase |
| tmr_ignore | input | 1 | 1 = exit on SE0 only; 0 = SE0 or timeout |
| lf_susp_en | input | 1 | Low-frequency suspend option; enables resume validation |
| val_count | input | VAL_W | Required consecutive K cycles for a valid resume |
| opmode | output | 2 | PHY operating mode: 2'b00 normal, 2'b10 non-driving |
| rsm_valid | output | 1 | Resume validated |
| exit_done | output | 1 | One-cycle pulse on return to normal mode |

## Verification
The bench builds the block with its defaults: a TIMEOUT of 200 cycles and an 8-bit validation count. These defaults keep the real timeout cheap to reach in every iteration. Random SE0 arrival times on both sides of 200 therefore exercise the choice between SE0 and timeout in both policy settings. Validation counts are kept small so that random K/J patterns produce both completed runs and interrupted ones.

// File: rtl/rsm_exit_pkg.sv
package rsm_exit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESUME = 2'd1,
        ST_EXIT   = 2'd2
    } rsm_state_e;

    typedef logic [1:0] opmode_t;
    localparam opmode_t OPM_NORMAL  = 2'b00;
    localparam opmode_t OPM_NODRIVE = 2'b10;

    localparam logic [1:0] LS_SE0 = 2'b00;
    localparam logic [1:0] LS_K   = 2'b10;

    typedef struct packed {
        logic tmr_off;
        logic lf_susp;
    } rsm_cfg_t;

    function automatic logic ls_is_se0(input logic [1:0] ls);
        return ls == LS_SE0;
    endfunction

    function automatic logic ls_is_k(input logic [1:0] ls);
        return ls == LS_K;
    endfunction

endpackage

// File: rtl/rsm_exit_timer.sv
module rsm_exit_timer #(
    parameter int TIMEOUT = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = (cnt == LIM);

    // R6: counter never passes its terminal value
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst) cnt <= LIM);
    // R6: entry clears the count
    a_r6_clear_on_entry: assert property (@(posedge clk) disable iff (rst) clr |=> cnt == '0);

endmodule

// File: rtl/rsm_valid_ctr.sv
module rsm_valid_ctr
    import rsm_exit_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             clr,
    input  logic             lf_en,
    input  logic [1:0]       ls,
    input  logic [VAL_W-1:0] need,
    output logic             valid
);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    logic [VAL_W-1:0] run;
    logic [VAL_W-1:0] run_nxt;
    logic [VAL_W-1:0] need_eff;

    always_comb begin
        run_nxt  = (run == '1) ? run : run + 1'b1;
        need_eff = (need == '0) ? ONE : need;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run   <= '0;
            valid <= 1'b0;
        end else if (arm) begin
            if (!lf_en) begin
                valid <= 1'b1;
            end else if (ls_is_k(ls)) begin
                run <= run_nxt;
                if (run_nxt >= need_eff) begin
                    valid <= 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end

    // R8: a non-K sample restarts the run
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (arm && lf_en && !ls_is_k(ls) && !clr) |=> run == '0);
    // R9: without validation the flag follows the first resume cycle
    a_r9_immediate: assert property (@(posedge clk) disable iff (rst)
        (arm && !lf_en && !clr) |=> valid);
    // R7: once raised the flag holds until cleared
    a_r7_valid_hold: assert property (@(posedge clk) disable iff (rst)
        (valid && !clr) |=> valid);

endmodule

// File: rtl/rsm_exit_ctrl.sv
module rsm_exit_ctrl
    import rsm_exit_pkg::*;
#(
    parameter int TIMEOUT = 200,
    parameter int VAL_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       line_st,
    input  logic             rsm_start,
    input  logic             rsm_end,
    input  logic             tmr_ignore,
    input  logic             lf_susp_en,
    input  logic [VAL_W-1:0] val_count,
    output logic [1:0]       opmode,
    output logic             rsm_valid,
    output logic             exit_done
);
    rsm_state_e state;
    rsm_state_e state_nxt;
    rsm_cfg_t   cfg;
    opmode_t    opm_q;
    logic       done_q;
    logic       start_acc;
    logic       end_acc;
    logic       exit_fire;
    logic       tmo_hit;
    logic       se0;

    always_comb begin
        cfg.tmr_off = tmr_ignore;
        cfg.lf_susp = lf_susp_en;
        se0         = ls_is_se0(line_st);
        start_acc   = (state == ST_IDLE) && rsm_start;
        end_acc     = (state == ST_RESUME) && rsm_end;
        exit_fire   = (state == ST_EXIT) && (se0 || (!cfg.tmr_off && tmo_hit));
        state_nxt   = state;
        unique case (state)
            ST_IDLE:   if (start_acc) state_nxt = ST_RESUME;
            ST_RESUME: if (end_acc)   state_nxt = ST_EXIT;
            ST_EXIT:   if (exit_fire) state_nxt = ST_IDLE;
            default:                  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            opm_q  <= OPM_NORMAL;
            done_q <= 1'b0;
        end else begin
            state  <= state_nxt;
            done_q <= exit_fire;
            if (start_acc) begin
                opm_q <= OPM_NODRIVE;
            end else if (exit_fire) begin
                opm_q <= OPM_NORMAL;
            end
        end
    end

    rsm_exit_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (end_acc),
        .run (state == ST_EXIT),
        .hit (tmo_hit)
    );

    rsm_valid_ctr #(.VAL_W(VAL_W)) u_valid (
        .clk   (clk),
        .rst   (rst),
        .arm   (state == ST_RESUME),
        .clr   (start_acc || exit_fire),
        .lf_en (cfg.lf_susp),
        .ls    (line_st),
        .need  (val_count),
        .valid (rsm_valid)
    );

    assign opmode    = opm_q;
    assign exit_done = done_q;

    // R2: only the two legal modes appear
    a_r2_opmode_legal: assert property (@(posedge clk) disable iff (rst)
        (opmode == OPM_NORMAL) || (opmode == OPM_NODRIVE));
    // R5: done marks the switch to normal mode
    a_r5_done_edge: assert property (@(posedge clk) disable iff (rst)
        exit_done |-> (opmode == OPM_NORMAL && $past(opmode) == OPM_NODRIVE));
    // R5: single-cycle pulse
    a_r5_single: assert property (@(posedge clk) disable iff (rst) exit_done |=> !exit_done);
    // R3: SE0 in the exit phase ends it
    a_r3_se0_exit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXIT && se0) |=> exit_done);
    // R4: with the timer ignored, no exit without SE0
    a_r4_no_timeout: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXIT && tmr_ignore && !se0) |=> !exit_done);
    // R10: idle never jumps straight to the exit phase
    a_r10_no_skip: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> state != ST_EXIT);

endmodule

// File: tb/rsm_exit_ctrl_bench.sv
module rsm_exit_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 200;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] line_st;
    logic       rsm_start;
    logic       rsm_end;
    logic       tmr_ignore;
    logic       lf_susp_en;
    logic [7:0] val_count;
    logic [1:0] opmode;
    logic       rsm_valid;
    logic       exit_done;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsm_exit_ctrl #(.TIMEOUT(TMO), .VAL_W(8)) u_rsm_exit_ctrl (
        .clk(clk), .rst(rst), .line_st(line_st), .rsm_start(rsm_start),
        .rsm_end(rsm_end), .tmr_ignore(tmr_ignore), .lf_susp_en(lf_susp_en),
        .val_count(val_count), .opmode(opmode), .rsm_valid(rsm_valid),
        .exit_done(exit_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_exit(input bit tmr, input int se0_at);
        if (tmr) return se0_at;
        return (se0_at < TMO) ? se0_at : TMO;
    endfunction

    // full sequence: start, rlen resume edges (last carries rsm_end), exit phase
    task automatic run_seq(input bit tmr, input bit lf, input int n, input int kpct,
                           input int rlen, input int se0_at, input string exit_tag);
        int run = 0;
        bit ev = 0;
        int need = (n == 0) ? 1 : n;
        int verr = 0;
        int perr = 0;
        int k_done = 0;
        int ek;
        tmr_ignore = tmr;
        lf_susp_en = lf;
        val_count  = 8'(n);
        line_st    = 2'b01;
        rsm_start  = 1'b1;
        tick();
        rsm_start  = 1'b0;
        chk(opmode == 2'b10, "R2", opmode, 2);
        for (int j = 1; j <= rlen; j++) begin
            bit isk = (($urandom % 100) < kpct);
            line_st = isk ? 2'b10 : 2'b01;
            if (j == rlen) rsm_end = 1'b1;
            tick();
            rsm_end = 1'b0;
            if (!lf) ev = 1;
            else if (isk) begin
                run++;
                if (run >= need) ev = 1;
            end else run = 0;
            if (rsm_valid !== ev) verr++;
            if (opmode !== 2'b10) perr++;
        end
        chk(verr == 0, lf ? "R7/R8 valid timing" : "R9 valid timing", verr, 0);
        for (int k = 1; k <= 400; k++) begin
            line_st = (k >= se0_at) ? 2'b00 : 2'b01;
            tick();
            if (exit_done) begin
                k_done = k;
                break;
            end
            if (opmode !== 2'b10 || rsm_valid !== ev) perr++;
        end
        chk(perr == 0, "R2 hold", perr, 0);
        ek = exp_exit(tmr, se0_at);
        chk(k_done == ek, exit_tag, k_done, ek);
        chk(opmode == 2'b00 && rsm_valid == 1'b0, "R5 state at done", {opmode, rsm_valid}, 0);
        line_st = 2'b01;
        tick();
        chk(exit_done == 1'b0 && opmode == 2'b00, "R5 pulse width", exit_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        int bad;
        seed = $urandom(32'd20240);
        rst = 1'b1; line_st = 2'b01; rsm_start = 1'b0; rsm_end = 1'b0;
        tmr_ignore = 1'b0; lf_susp_en = 1'b0; val_count = 8'd2;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk(opmode == 2'b00, "R1 opmode", opmode, 0);
        chk(rsm_valid == 1'b0, "R1 valid", rsm_valid, 0);
        chk(exit_done == 1'b0, "R1 done", exit_done, 0);

        // R10: rsm_end while idle
        rsm_end = 1'b1; tick(); rsm_end = 1'b0;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            line_st = 2'b00;
            tick();
            if (opmode !== 2'b00 || exit_done !== 1'b0) bad++;
        end
        line_st = 2'b01;
        chk(bad == 0, "R10 end ignored in idle", bad, 0);

        // R3 timeout only, SE0 early, R4 SE0 only past the timeout
        run_seq(1'b0, 1'b0, 2, 0, 3, 300, "R3 timeout");
        run_seq(1'b0, 1'b0, 2, 0, 3, 37,  "R3 SE0 first");
        run_seq(1'b1, 1'b0, 2, 0, 3, 260, "R4 timeout ignored");
        // R6: earlier partial count must not shorten the next timeout
        run_seq(1'b0, 1'b0, 2, 0, 2, 150, "R3 SE0 at 150");
        run_seq(1'b0, 1'b0, 2, 0, 2, 300, "R6 fresh timeout");
        // R7 steady K, R8 interrupted K, R9 no validation
        run_seq(1'b0, 1'b1, 5, 100, 8, 10, "R3 after R7");
        run_seq(1'b0, 1'b1, 5, 60, 20, 10, "R3 after R8");
        run_seq(1'b0, 1'b0, 9, 0, 4, 10, "R3 after R9");

        // R10: rsm_start during resume and exit ignored
        tmr_ignore = 1'b0; lf_susp_en = 1'b0; line_st = 2'b01;
        rsm_start = 1'b1; tick(); tick();
        rsm_end = 1'b1; tick(); rsm_end = 1'b0;
        tick(); tick();
        line_st = 2'b00; tick();
        rsm_start = 1'b0; line_st = 2'b01;
        chk(exit_done == 1'b1 && opmode == 2'b00, "R10 start ignored", exit_done, 1);

        // constrained random sequences
        for (int it = 0; it < 40; it++) begin
            bit tm = $urandom % 2;
            bit lf = $urandom % 2;
            int n  = $urandom % 12;
            int rl = 2 + ($urandom % 25);
            int sa = 1 + ($urandom % 290);
            run_seq(tm, lf, n, 75, rl, sa, tm ? "R4 random" : "R3 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule